// File: doc/BRIEF.md
# Single-Wire Bus Slave Bit Engine

This block is the bit-level slave for a single-wire, open-drain bus whose idle level is high. It runs from a system clock divided down to a 1 µs timebase. It watches the sampled bus line and drives one output that enables an external pull-down. Every time slot starts when the master pulls the line low, and the block times everything from that falling edge. It turns master write slots into received bits. It drives read slots from a bit that the layer above supplies. It recognises long low levels as bus resets and answers each one with a presence pulse inside a fixed window.

The layer above sets `tx_en` and `tx_bit` before a slot begins. The block captures both values in the cycle it detects the falling edge, and `tx_req` marks the first cycle of that slot. Every slot yields a sampled bit on `rx_bit` with the strobe `rx_valid`, whether the slot was a read or a write. The layer above keeps the bits that matter to it. Because a reset also begins with a falling edge, it yields one sampled 0 before `rst_evt`. The layer above discards that bit when the reset event arrives. Assembling bits into bytes, decoding commands and the faster bus speed all belong to other blocks.

Top module: `owb_bit_slave`

## Requirements
- R1: During and directly after reset, `bus_pull`, `rx_valid`, `tx_req` and `rst_evt` are all 0.
- R2: The line passes through a two-flop synchronizer and a filter. A low pulse shorter than `CLK_PER_US` clock cycles (1 µs) produces no `tx_req` and no `rx_valid`.
- R3: Each falling edge accepted while the bus is idle produces exactly one single-cycle `tx_req`. Exactly `SAMPLE_US` (30) µs later it produces exactly one single-cycle `rx_valid`.
- R4: `rx_bit` carries the filtered line level at the sample point. A master low time of 1 to 15 µs gives `rx_bit`=1. A master low time of 60 to 120 µs gives `rx_bit`=0.
- R5: When `tx_en`=1 and `tx_bit`=0 at the falling edge, `bus_pull` is 1 from the first slot cycle until `HOLD_US` (15) µs after it, and then releases. The pull has ended before the sample point.
- R6: When `tx_en`=0, or when `tx_bit`=1, the block never asserts `bus_pull` during that slot.
- R7: A line low for at least `RESET_US` (480) µs produces one single-cycle `rst_evt` when the line rises. A 470 µs low produces no `rst_evt`.
- R8: The presence pulse starts `PDLY_US` (30) µs after the rise that ended the reset. During it `bus_pull` is 1 for exactly `PWID_US` (120) µs, that is `PWID_US*CLK_PER_US` cycles. No `rst_evt` coincides with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | 1 | Raw bus line level, asynchronous (1 = released/high) |
| bus_pull | output | 1 | Pull-down enable for the open-drain bus driver |
| tx_en | input | 1 | 1 = the next slot is a read slot driven by this slave |
| tx_bit | input | 1 | Bit to send in the next read slot |
| tx_req | output | 1 | One-cycle pulse in the first cycle of each slot |
| rx_bit | output | 1 | Bit sampled in the latest slot |
| rx_valid | output | 1 | One-cycle strobe: `rx_bit` is new |
| rst_evt | output | 1 | One-cycle pulse when a bus reset ends |

## Verification
The assertions assume a master that keeps to slot timing. Falling edges are spaced by more than `SAMPLE_US` plus the recovery time. The master never pulls the line during a presence pulse. Under those assumptions the strobes are single-cycle and a pull never overlaps a sample. The stimulus follows the same rules: each slot lasts 130 µs, including at least 10 µs of high recovery. Resets are released and then left high until the presence pulse has ended. The only exception is a deliberate glitch shorter than 1 µs.

// File: rtl/owb_pkg.sv
// Package: shared state type for the single-wire bit slave.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package owb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,  // line high, waiting for a falling edge
        ST_SLOT    = 3'd1,  // timing a slot up to the sample point
        ST_LOWWAIT = 3'd2,  // line still low after sampling
        ST_RSTHELD = 3'd3,  // reset length reached, waiting for the rise
        ST_PGAP    = 3'd4,  // delay before the presence pulse
        ST_PDRIVE  = 3'd5,  // presence pulse being driven
        ST_PREL    = 3'd6   // presence released, waiting for high line
    } owb_state_t;

endpackage

// File: rtl/owb_timebase.sv
// Module: owb_timebase
// Divides the system clock into a one-cycle tick per microsecond.
// The divider can be restarted, so ticks line up with a bus edge.
// Assumes CLK_PER_US >= 2.
module owb_timebase #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] PMAX = PW'(CLK_PER_US - 1);

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == PMAX);

    // Prescale counter; a restart puts the next tick one full period away.
    always_ff @(posedge clk) begin
        if (!rst_n)      pcnt <= '0;
        else if (clr)    pcnt <= '0;
        else if (tick)   pcnt <= '0;
        else             pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/owb_line_filter.sv
// Module: owb_line_filter
// Synchronises the raw bus level with two flops. The filtered output
// only follows a new level after it has been stable for GLITCH_CYC
// cycles in a row, so shorter pulses are dropped.
// Assumes the bus idles high, so every flop resets to 1.
module owb_line_filter #(
    parameter int GLITCH_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic line
);
    localparam int FW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;
    localparam logic [FW-1:0] FMAX = FW'(GLITCH_CYC - 1);

    logic          s1, s2;
    logic [FW-1:0] fcnt;

    // Two-stage synchronizer for the asynchronous bus input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= raw;
            s2 <= s1;
        end
    end

    // Persistence filter: accept a new level after GLITCH_CYC equal samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt <= '0;
            line <= 1'b1;
        end else if (s2 == line) begin
            fcnt <= '0;
        end else if (fcnt == FMAX) begin
            fcnt <= '0;
            line <= s2;
        end else begin
            fcnt <= fcnt + 1'b1;
        end
    end
endmodule

// File: rtl/owb_slot_engine.sv
// Module: owb_slot_engine
// Slot and reset sequencer, counting in microsecond ticks.
// It starts a slot on each falling edge of the filtered line and
// samples the written bit. For a read-0 slot it holds the line low.
// It recognises reset lows and produces the presence pulse.
// Assumes SAMPLE_US > HOLD_US and RESET_US > SAMPLE_US.
module owb_slot_engine
    import owb_pkg::*;
#(
    parameter int SAMPLE_US = 30,
    parameter int HOLD_US   = 15,
    parameter int RESET_US  = 480,
    parameter int PDLY_US   = 30,
    parameter int PWID_US   = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic tick,
    input  logic tx_en,
    input  logic tx_bit,
    output logic tb_clr,
    output logic pull,
    output logic tx_req,
    output logic rx_bit,
    output logic rx_valid,
    output logic rst_evt
);
    localparam int MAXV = (RESET_US > PWID_US) ? RESET_US : PWID_US;
    localparam int CW   = $clog2(MAXV + 1);
    localparam logic [CW-1:0] C_SAMP = CW'(SAMPLE_US - 1);
    localparam logic [CW-1:0] C_HOLD = CW'(HOLD_US);
    localparam logic [CW-1:0] C_RST  = CW'(RESET_US - 1);
    localparam logic [CW-1:0] C_PDLY = CW'(PDLY_US - 1);
    localparam logic [CW-1:0] C_PWID = CW'(PWID_US - 1);

    owb_state_t     state;
    logic [CW-1:0]  ucnt;
    logic           drv0;

    // Restart the timebase on a slot edge and on the rise that ends a reset.
    assign tb_clr = ((state == ST_IDLE) && !line) ||
                    ((state == ST_RSTHELD) && line);

    // Pull-down: the presence pulse, or the early part of a read-0 slot.
    assign pull = (state == ST_PDRIVE) ||
                  ((state == ST_SLOT) && drv0 && (ucnt < C_HOLD));

    // Main sequencer: state, microsecond count and event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ucnt     <= '0;
            drv0     <= 1'b0;
            tx_req   <= 1'b0;
            rx_bit   <= 1'b1;
            rx_valid <= 1'b0;
            rst_evt  <= 1'b0;
        end else begin
            tx_req   <= 1'b0;
            rx_valid <= 1'b0;
            rst_evt  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (!line) begin
                        state  <= ST_SLOT;
                        ucnt   <= '0;
                        tx_req <= 1'b1;
                        drv0   <= tx_en & ~tx_bit;
                    end
                end
                ST_SLOT: begin
                    if (tick) begin
                        ucnt <= ucnt + 1'b1;
                        if (ucnt == C_SAMP) begin
                            rx_bit   <= line;
                            rx_valid <= 1'b1;
                            drv0     <= 1'b0;
                            state    <= line ? ST_IDLE : ST_LOWWAIT;
                        end
                    end
                end
                ST_LOWWAIT: begin
                    if (line) begin
                        state <= ST_IDLE;
                    end else if (tick) begin
                        ucnt <= ucnt + 1'b1;
                        if (ucnt == C_RST) state <= ST_RSTHELD;
                    end
                end
                ST_RSTHELD: begin
                    if (line) begin
                        rst_evt <= 1'b1;
                        ucnt    <= '0;
                        state   <= ST_PGAP;
                    end
                end
                ST_PGAP: begin
                    if (tick) begin
                        ucnt <= ucnt + 1'b1;
                        if (ucnt == C_PDLY) begin
                            ucnt  <= '0;
                            state <= ST_PDRIVE;
                        end
                    end
                end
                ST_PDRIVE: begin
                    if (tick) begin
                        ucnt <= ucnt + 1'b1;
                        if (ucnt == C_PWID) begin
                            ucnt  <= '0;
                            state <= ST_PREL;
                        end
                    end
                end
                ST_PREL: begin
                    if (line) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/owb_bit_slave.sv
// Module: owb_bit_slave (top)
// Bit-level slave for a single-wire open-drain bus. It chains the
// input filter, the microsecond timebase and the slot sequencer.
// Assumes bus_in is the raw line level, asynchronous to clk, and that
// bus_pull drives an external open-drain pull-down.
module owb_bit_slave #(
    parameter int CLK_PER_US = 50,
    parameter int SAMPLE_US  = 30,
    parameter int HOLD_US    = 15,
    parameter int RESET_US   = 480,
    parameter int PDLY_US    = 30,
    parameter int PWID_US    = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_in,
    output logic bus_pull,
    input  logic tx_en,
    input  logic tx_bit,
    output logic tx_req,
    output logic rx_bit,
    output logic rx_valid,
    output logic rst_evt
);
    logic line_f;
    logic tick;
    logic tb_clr;

    owb_line_filter #(.GLITCH_CYC(CLK_PER_US)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (bus_in),
        .line (line_f)
    );

    owb_timebase #(.CLK_PER_US(CLK_PER_US)) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tb_clr),
        .tick (tick)
    );

    owb_slot_engine #(
        .SAMPLE_US(SAMPLE_US),
        .HOLD_US  (HOLD_US),
        .RESET_US (RESET_US),
        .PDLY_US  (PDLY_US),
        .PWID_US  (PWID_US)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (line_f),
        .tick    (tick),
        .tx_en   (tx_en),
        .tx_bit  (tx_bit),
        .tb_clr  (tb_clr),
        .pull    (bus_pull),
        .tx_req  (tx_req),
        .rx_bit  (rx_bit),
        .rx_valid(rx_valid),
        .rst_evt (rst_evt)
    );
endmodule

// File: rtl/owb_bit_checker.sv
// Module: owb_bit_checker
// Port-level properties of owb_bit_slave, attached by bind.
// Assumes a master that keeps to slot timing and recovery rules.
module owb_bit_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_pull,
    input logic tx_req,
    input logic rx_valid,
    input logic rst_evt
);
    // R3: the slot-start strobe lasts a single cycle.
    p_txreq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    // R3: the receive strobe lasts a single cycle.
    p_rxvalid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: a read-0 hold has ended before the sample point.
    p_pull_before_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !bus_pull);

    // R7: the reset event lasts a single cycle.
    p_rst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> !rst_evt);

    // R7: a reset event never coincides with a slot start.
    p_rst_not_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |-> !tx_req);

    // R8: the presence pulse never starts on the reset-event cycle.
    p_no_pull_at_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> !bus_pull);
endmodule

bind owb_bit_slave owb_bit_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_pull(bus_pull),
    .tx_req  (tx_req),
    .rx_valid(rx_valid),
    .rst_evt (rst_evt)
);

// File: tb/sim_owb_bit_slave.sv
// Bench: sweeps write-slot low times and covers read slots, glitches,
// a near-reset low and full resets with presence timing.
module sim_owb_bit_slave;
    localparam int CPU = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_low = 1'b0;
    logic tx_en = 1'b0;
    logic tx_bit = 1'b1;
    logic bus_pull, tx_req, rx_bit, rx_valid, rst_evt;
    logic bus;

    int n_chk = 0;
    int n_fail = 0;
    int rxv_cnt = 0, txr_cnt = 0, rst_cnt = 0, pull_cyc = 0;
    logic last_rx = 1'b1;
    bit done = 1'b0;

    assign bus = ~(m_low | bus_pull);

    always #10 clk = ~clk;

    owb_bit_slave #(.CLK_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_in(bus), .bus_pull(bus_pull),
        .tx_en(tx_en), .tx_bit(tx_bit), .tx_req(tx_req),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .rst_evt(rst_evt)
    );

    // Event monitor: counts strobes and pull cycles.
    always @(posedge clk) begin
        if (rx_valid) begin rxv_cnt <= rxv_cnt + 1; last_rx <= rx_bit; end
        if (tx_req)   txr_cnt  <= txr_cnt + 1;
        if (rst_evt)  rst_cnt  <= rst_cnt + 1;
        if (bus_pull) pull_cyc <= pull_cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_us(input int us);
        repeat (us * CPU) @(negedge clk);
    endtask

    // One master slot: low for low_us, then high to fill a 130 us slot.
    task automatic slot(input int low_us);
        m_low = 1'b1;
        wait_us(low_us);
        m_low = 1'b0;
        wait_us(130 - low_us);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs quiet while in reset
        chk(bus_pull == 0 && rx_valid == 0 && tx_req == 0 && rst_evt == 0,
            "R1", {bus_pull, rx_valid, tx_req, rst_evt}, 0);
        rst_n = 1'b1;
        wait_us(5);
        chk(bus_pull == 0 && rxv_cnt == 0 && txr_cnt == 0 && rst_cnt == 0,
            "R1", rxv_cnt + txr_cnt + rst_cnt, 0);

        // R2: glitch of CPU-2 cycles is ignored
        m_low = 1'b1;
        repeat (CPU - 2) @(negedge clk);
        m_low = 1'b0;
        wait_us(60);
        chk(txr_cnt == 0, "R2 tx_req", txr_cnt, 0);
        chk(rxv_cnt == 0, "R2 rx_valid", rxv_cnt, 0);

        // R4/R3: write-1 sweep, 1..15 us low
        for (int l = 1; l <= 15; l++) begin
            int b_rx, b_tx;
            b_rx = rxv_cnt; b_tx = txr_cnt;
            slot(l);
            chk(rxv_cnt == b_rx + 1, "R3 rx_valid once", rxv_cnt - b_rx, 1);
            chk(txr_cnt == b_tx + 1, "R3 tx_req once", txr_cnt - b_tx, 1);
            chk(last_rx == 1'b1, "R4 write-1", int'(last_rx), 1);
        end

        // R4: write-0 sweep, 60..120 us low
        for (int l = 60; l <= 120; l += 10) begin
            int b_rx;
            b_rx = rxv_cnt;
            slot(l);
            chk(rxv_cnt == b_rx + 1, "R3 rx_valid once", rxv_cnt - b_rx, 1);
            chk(last_rx == 1'b0, "R4 write-0", int'(last_rx), 0);
        end

        // R3: rx_valid arrives at 30 us after the edge, not before
        begin
            int b_rx;
            b_rx = rxv_cnt;
            m_low = 1'b1; wait_us(2); m_low = 1'b0;
            wait_us(27);
            chk(rxv_cnt == b_rx, "R3 early", rxv_cnt - b_rx, 0);
            wait_us(4);
            chk(rxv_cnt == b_rx + 1, "R3 at sample", rxv_cnt - b_rx, 1);
            wait_us(97);
        end

        // R5: read-0 slot, slave holds line low then releases
        tx_en = 1'b1; tx_bit = 1'b0;
        m_low = 1'b1; wait_us(2); m_low = 1'b0;
        wait_us(8);
        chk(bus == 1'b0, "R5 held at 10us", int'(bus), 0);
        wait_us(10);
        chk(bus == 1'b1, "R5 released at 20us", int'(bus), 1);
        tx_en = 1'b0; tx_bit = 1'b1;
        wait_us(110);

        // R6: read-1 slot and disabled slot never pull
        for (int k = 0; k < 2; k++) begin
            int b_p;
            tx_en = (k == 0); tx_bit = (k == 0) ? 1'b1 : 1'b0;
            b_p = pull_cyc;
            m_low = 1'b1; wait_us(2); m_low = 1'b0;
            wait_us(8);
            chk(bus == 1'b1, "R6 line high at 10us", int'(bus), 1);
            wait_us(120);
            chk(pull_cyc == b_p, "R6 no pull", pull_cyc - b_p, 0);
        end
        tx_en = 1'b0; tx_bit = 1'b1;

        // R7: 470 us low is not a reset
        begin
            int b_r;
            b_r = rst_cnt;
            slot(470 - 130 + 130 > 0 ? 0 : 0);
            m_low = 1'b1; wait_us(470); m_low = 1'b0;
            wait_us(300);
            chk(rst_cnt == b_r, "R7 470us no reset", rst_cnt - b_r, 0);
        end

        // R7/R8: two full resets with presence pulses
        for (int k = 0; k < 2; k++) begin
            int b_r, b_p;
            b_r = rst_cnt; b_p = pull_cyc;
            m_low = 1'b1; wait_us(500 + 20 * k); m_low = 1'b0;
            wait_us(20);
            chk(rst_cnt == b_r + 1, "R7 reset event", rst_cnt - b_r, 1);
            chk(bus == 1'b1, "R8 gap high at 20us", int'(bus), 1);
            wait_us(20);
            chk(bus == 1'b0, "R8 pulled at 40us", int'(bus), 0);
            wait_us(100);
            chk(bus == 1'b0, "R8 pulled at 140us", int'(bus), 0);
            wait_us(20);
            chk(bus == 1'b1, "R8 released at 160us", int'(bus), 1);
            chk(pull_cyc - b_p == 120 * CPU, "R8 width", pull_cyc - b_p, 120 * CPU);
            wait_us(40);
        end

        // R4: slot right after presence still decodes
        slot(70);
        chk(last_rx == 1'b0, "R4 after presence", int'(last_rx), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule